// File: doc/BRIEF.md
# Dual-Pointer Rolling-Shutter Row Addresser

This block drives the row-select lines of an image-sensor pixel array. It holds two independent row pointers, each kept as a one-hot vector. The read pointer marks the row being read out. The shutter pointer marks the row being reset, and the gap between the two pointers sets the exposure of a rolling electronic shutter.

Software writes a start row for each pointer through a small parallel configuration port. A load strobe copies that start row into its pointer and switches the pointer on. From then on, every advance strobe moves the pointer forward by one row. After the last row the pointer wraps to row 0.

A two-bit scan-mode input selects which pointers take part. In destructive readout both pointers run. In non-destructive readout the user can run the read pointer alone, the shutter pointer alone, or both. A pointer that the mode leaves out shows no selected row and keeps its position until the mode lets it run again.

Top module: `rowsel_dual_addresser`

## Requirements
- R1: Synchronous active-high reset turns both pointers off, so both row outputs are all zeros, and clears both start rows to 0. A load issued right after reset therefore selects row 0.
- R2: A write with `cfg_addr` = 1 sets the read start row. A write with `cfg_addr` = 2 sets the shutter start row. A load uses the register value from the cycle before the load edge.
- R3: A write to any address other than 1 or 2 changes neither start row.
- R4: A written value of `NUM_ROWS` or more is stored as `NUM_ROWS-1`.
- R5: When its pointer is permitted, a load strobe turns the pointer on. One cycle later the output has exactly bit `start` set.
- R6: While its pointer is on and permitted, each cycle with the advance strobe high (and load low) moves the set bit from index i to index i+1.
- R7: Advancing from row `NUM_ROWS-1` selects row 0.
- R8: When load and advance are both high in the same cycle, the load takes effect and the advance is discarded.
- R9: While a pointer is on and permitted, its output has exactly one bit set. A pointer that has not been loaded since reset outputs all zeros.
- R10: `scan_mode` encodes the active pointers: 0 = destructive readout with both pointers; 1 = non-destructive, read pointer only; 2 = non-destructive, shutter pointer only; 3 = non-destructive, both pointers. A pointer that is not permitted outputs all zeros in the same cycle, ignores its load and advance strobes, and shows its held position again once it is permitted.
- R11: The strobes of one pointer never move the other pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | 4 | Configuration register address |
| cfg_data | input | DATA_W | Configuration write data |
| cfg_we | input | 1 | Configuration write strobe |
| rd_load | input | 1 | Load read pointer from its start row |
| rd_step | input | 1 | Advance read pointer one row |
| sh_load | input | 1 | Load shutter pointer from its start row |
| sh_step | input | 1 | Advance shutter pointer one row |
| scan_mode | input | 2 | Pointer participation mode (see R10) |
| rd_rows | output | NUM_ROWS | One-hot read row select |
| sh_rows | output | NUM_ROWS | One-hot shutter row select |

## Verification
A load or advance strobe shows on the row outputs one clock after the edge that samples it. A configuration write takes effect for a load issued in the next cycle or later. A change of `scan_mode` gates the outputs in the same cycle, with no clock in between. The bench drives every input just after a falling edge and samples the outputs at the following falling edge, which is half a period after the only rising edge that can have updated them. For strobes that must have no effect, it moves to a permitting mode and loads again, so the held position or start row shows up at the outputs.

// File: rtl/rowsel_pkg.sv
package rowsel_pkg;

    localparam int CFG_ADDR_W = 4;

    localparam logic [CFG_ADDR_W-1:0] ADDR_RD_START = 4'h1;
    localparam logic [CFG_ADDR_W-1:0] ADDR_SH_START = 4'h2;

    typedef enum logic [1:0] {
        SM_DESTRUCTIVE = 2'd0,
        SM_NDR_READ    = 2'd1,
        SM_NDR_SHUTTER = 2'd2,
        SM_NDR_BOTH    = 2'd3
    } scan_mode_e;

    typedef enum logic {
        PTR_READ    = 1'b0,
        PTR_SHUTTER = 1'b1
    } ptr_id_e;

    function automatic logic ptr_permitted(scan_mode_e m, ptr_id_e id);
        case (m)
            SM_NDR_READ:    return id == PTR_READ;
            SM_NDR_SHUTTER: return id == PTR_SHUTTER;
            default:        return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/rowsel_start_regs.sv
module rowsel_start_regs
    import rowsel_pkg::*;
#(
    parameter int NUM_ROWS = 12,
    parameter int DATA_W   = 8,
    localparam int ROW_W   = $clog2(NUM_ROWS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]     cfg_data,
    input  logic                  cfg_we,
    output logic [ROW_W-1:0]      rd_start,
    output logic [ROW_W-1:0]      sh_start
);
    localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(NUM_ROWS - 1);

    logic [ROW_W-1:0] clamped;

    always_comb begin
        if (cfg_data >= DATA_W'(NUM_ROWS)) clamped = ROW_MAX;
        else                               clamped = cfg_data[ROW_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_start <= '0;
            sh_start <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_RD_START) rd_start <= clamped;
            if (cfg_addr == ADDR_SH_START) sh_start <= clamped;
        end
    end

    // R3: foreign addresses leave both start rows untouched
    p_ignore_other_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr != ADDR_RD_START && cfg_addr != ADDR_SH_START)
        |=> ($stable(rd_start) && $stable(sh_start)));

    // R4: stored start rows never exceed the last row
    p_start_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_start <= ROW_MAX) && (sh_start <= ROW_MAX));

    // R2: a write to the read start address lands in the read register
    p_rd_write_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADDR_RD_START && cfg_data < DATA_W'(NUM_ROWS))
        |=> rd_start == $past(cfg_data[ROW_W-1:0]));

endmodule

// File: rtl/rowsel_pointer.sv
module rowsel_pointer #(
    parameter int NUM_ROWS = 12,
    localparam int ROW_W   = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                permit,
    input  logic                load,
    input  logic                step,
    input  logic [ROW_W-1:0]    start,
    output logic [NUM_ROWS-1:0] rows
);
    logic [NUM_ROWS-1:0] vec_q;
    logic [NUM_ROWS-1:0] start_dec;
    logic                on_q;

    always_comb begin
        for (int i = 0; i < NUM_ROWS; i++) begin
            start_dec[i] = (start == ROW_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            on_q  <= 1'b0;
        end else if (permit) begin
            if (load) begin
                vec_q <= start_dec;
                on_q  <= 1'b1;
            end else if (step && on_q) begin
                vec_q <= {vec_q[NUM_ROWS-2:0], vec_q[NUM_ROWS-1]};
            end
        end
    end

    assign rows = (on_q && permit) ? vec_q : '0;

    // R9: an active pointer holds exactly one row
    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        on_q |-> $countones(vec_q) == 1);

    // R6 / R7: an advance rotates by one position, wrapping at the top
    p_step_rotates_r6: assert property (@(posedge clk) disable iff (rst)
        (permit && step && !load && on_q)
        |=> vec_q == {$past(vec_q[NUM_ROWS-2:0]), $past(vec_q[NUM_ROWS-1])});

    // R8: load takes priority over a simultaneous advance
    p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (permit && load)
        |=> vec_q == (NUM_ROWS'(1) << $past(start)));

    // R10: a pointer left out by the mode keeps its state
    p_gated_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !permit |=> ($stable(vec_q) && $stable(on_q)));

endmodule

// File: rtl/rowsel_dual_addresser.sv
module rowsel_dual_addresser
    import rowsel_pkg::*;
#(
    parameter int NUM_ROWS = 12,
    parameter int DATA_W   = 8,
    localparam int ROW_W   = $clog2(NUM_ROWS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]     cfg_data,
    input  logic                  cfg_we,
    input  logic                  rd_load,
    input  logic                  rd_step,
    input  logic                  sh_load,
    input  logic                  sh_step,
    input  logic [1:0]            scan_mode,
    output logic [NUM_ROWS-1:0]   rd_rows,
    output logic [NUM_ROWS-1:0]   sh_rows
);
    localparam int NUM_PTRS = 2;

    logic [ROW_W-1:0]    start_v [NUM_PTRS];
    logic [NUM_ROWS-1:0] rows_v  [NUM_PTRS];
    logic [NUM_PTRS-1:0] load_v;
    logic [NUM_PTRS-1:0] step_v;
    scan_mode_e          mode;

    assign mode   = scan_mode_e'(scan_mode);
    assign load_v = {sh_load, rd_load};
    assign step_v = {sh_step, rd_step};

    rowsel_start_regs #(
        .NUM_ROWS (NUM_ROWS),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .cfg_we   (cfg_we),
        .rd_start (start_v[0]),
        .sh_start (start_v[1])
    );

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
        rowsel_pointer #(
            .NUM_ROWS (NUM_ROWS)
        ) u_ptr (
            .clk    (clk),
            .rst    (rst),
            .permit (ptr_permitted(mode, ptr_id_e'(g == 1))),
            .load   (load_v[g]),
            .step   (step_v[g]),
            .start  (start_v[g]),
            .rows   (rows_v[g])
        );
    end

    assign rd_rows = rows_v[0];
    assign sh_rows = rows_v[1];

    // R11: read strobes alone never move the shutter outputs
    p_independent_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_load || rd_step) && !sh_load && !sh_step && $stable(scan_mode)
        |=> (!$stable(scan_mode) || $stable(sh_rows)));

    // R9: outputs never carry more than one selected row
    p_out_onehot0_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_rows) && $onehot0(sh_rows));

endmodule

// File: tb/tb_rowsel_dual_addresser.sv
module tb_rowsel_dual_addresser;
    localparam int N  = 12;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    cfg_addr;
    logic [DW-1:0] cfg_data;
    logic          cfg_we;
    logic          rd_load, rd_step, sh_load, sh_step;
    logic [1:0]    scan_mode;
    logic [N-1:0]  rd_rows, sh_rows;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rowsel_dual_addresser #(.NUM_ROWS(N), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_we(cfg_we), .rd_load(rd_load), .rd_step(rd_step),
        .sh_load(sh_load), .sh_step(sh_step), .scan_mode(scan_mode),
        .rd_rows(rd_rows), .sh_rows(sh_rows)
    );

    function automatic logic [N-1:0] oh(int idx);
        return N'(1) << idx;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic write_reg(logic [3:0] a, logic [DW-1:0] d);
        cfg_addr = a; cfg_data = d; cfg_we = 1'b1;
        cycle();
        cfg_we = 1'b0;
    endtask

    task automatic pulse(logic rl, logic rs, logic sl, logic ss);
        rd_load = rl; rd_step = rs; sh_load = sl; sh_step = ss;
        cycle();
        rd_load = 0; rd_step = 0; sh_load = 0; sh_step = 0;
    endtask

    // R1, R9: reset state and default start rows
    task automatic t_reset();
        check("R1 rd after reset", rd_rows, '0);
        check("R9 sh unloaded", sh_rows, '0);
        pulse(1, 0, 1, 0);
        check("R1 rd start 0", rd_rows, oh(0));
        check("R1 sh start 0", sh_rows, oh(0));
    endtask

    // R2, R5, R11: separate start registers and loads
    task automatic t_write_load();
        write_reg(4'h1, 8'd5);
        write_reg(4'h2, 8'd9);
        pulse(1, 0, 0, 0);
        check("R5 rd load", rd_rows, oh(5));
        check("R11 sh untouched by rd load", sh_rows, oh(0));
        pulse(0, 0, 1, 0);
        check("R2 sh load", sh_rows, oh(9));
    endtask

    // R6, R11: stepping one row per strobe
    task automatic t_step();
        for (int i = 1; i <= 3; i++) begin
            pulse(0, 1, 0, 0);
            check("R6 rd step", rd_rows, oh(5 + i));
            check("R11 sh still", sh_rows, oh(9));
        end
        cycle();
        check("R6 no strobe holds", rd_rows, oh(8));
    endtask

    // R4, R7: clamping of large starts and wraparound
    task automatic t_wrap_clamp();
        write_reg(4'h1, 8'd200);
        pulse(1, 0, 0, 0);
        check("R4 clamp to last row", rd_rows, oh(N - 1));
        pulse(0, 1, 0, 0);
        check("R7 wrap to row 0", rd_rows, oh(0));
    endtask

    // R3: foreign addresses ignored
    task automatic t_ignore();
        write_reg(4'h1, 8'd3);
        write_reg(4'h2, 8'd7);
        write_reg(4'h0, 8'd1);
        write_reg(4'h3, 8'd2);
        write_reg(4'hF, 8'd4);
        pulse(1, 0, 1, 0);
        check("R3 rd start kept", rd_rows, oh(3));
        check("R3 sh start kept", sh_rows, oh(7));
    endtask

    // R8: load beats advance
    task automatic t_load_wins();
        pulse(0, 1, 0, 1);
        check("R6 rd step", rd_rows, oh(4));
        pulse(1, 1, 1, 1);
        check("R8 rd load wins", rd_rows, oh(3));
        check("R8 sh load wins", sh_rows, oh(7));
    endtask

    // R10: mode gating and held positions
    task automatic t_mode();
        scan_mode = 2'd1;
        cycle();
        check("R10 read-only sh zero", sh_rows, '0);
        check("R10 read-only rd live", rd_rows, oh(3));
        write_reg(4'h2, 8'd2);
        pulse(0, 0, 1, 0);
        pulse(0, 0, 0, 1);
        check("R10 gated sh stays zero", sh_rows, '0);
        scan_mode = 2'd0;
        cycle();
        check("R10 sh position held", sh_rows, oh(7));
        scan_mode = 2'd2;
        cycle();
        check("R10 shutter-only rd zero", rd_rows, '0);
        pulse(0, 1, 0, 1);
        check("R10 shutter-only sh steps", sh_rows, oh(8));
        scan_mode = 2'd3;
        cycle();
        check("R10 both rd held", rd_rows, oh(3));
        check("R10 both sh live", sh_rows, oh(8));
    endtask

    initial begin
        rst = 1'b1; cfg_addr = '0; cfg_data = '0; cfg_we = 1'b0;
        rd_load = 0; rd_step = 0; sh_load = 0; sh_step = 0;
        scan_mode = 2'd0;
        repeat (3) cycle();
        rst = 1'b0;
        cycle();
        t_reset();
        t_write_load();
        t_step();
        t_wrap_clamp();
        t_ignore();
        t_load_wins();
        t_mode();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule